// File: doc/BRIEF.md
# Wavefront Lane Swizzle Unit

This unit moves 32-bit values between the 64 lanes of one vector register. The issuer supplies the source vector, a 64-bit execution mask and two 8-bit offset fields that together form a 16-bit swizzle pattern. The top pattern bit picks one of two modes. In quad mode every aligned group of four lanes is shuffled by four 2-bit selectors. In mask mode each lane computes a source index as ((lane AND a) OR o) XOR x on the lane's 5-bit position inside its own 32-lane half.

Each active destination lane receives the selected source lane's value, or zero when that source lane is masked off. Lanes that are masked off are not written. Their stored destination values remain unchanged. The whole result is computed in one cycle, registered at issue, and released a fixed 24 cycles later. At that point the unit pulses a done flag and presents the destination vector together with a per-lane write-enable mask. Only one operation can be in flight at a time.

Top module: `lane_swizzle_unit`

## Requirements
- R1: The pattern is {offset_hi_i, offset_lo_i}, with offset_hi_i in bits 15:8. Pattern bit 15 set selects quad mode. Pattern bit 15 clear selects mask mode.
- R2: In quad mode, lane 4g+k takes the value of lane 4g + pattern[2k+1:2k], for k in 0..3.
- R3: In quad mode, pattern bits 14:8 have no effect on the result.
- R4: In mask mode, the fields are and = pattern[4:0], or = pattern[9:5] and xor = pattern[14:10]. Lane L reads index ((L mod 32) & and | or) ^ xor, computed on 5 bits. For L >= 32, 32 is added to that index.
- R5: A lane whose execution-mask bit is 0 has its wr_en_o bit at 0, and its dst_data_o value keeps its previous contents.
- R6: An active lane whose selected source lane has a 0 mask bit receives 0.
- R7: With an all-zero execution mask, done_o still pulses, wr_en_o is all zero and dst_data_o is unchanged.
- R8: A start is accepted on a clock edge where start_i is 1 and busy_o is 0. Exactly 24 edges later, dst_data_o and wr_en_o update and done_o is 1 for one cycle. Between done pulses, neither dst_data_o nor wr_en_o changes.
- R9: busy_o is 1 from the accepting edge until the done edge. A start_i arriving while busy_o is 1 is ignored and produces no extra done pulse.
- R10: After reset, busy_o, done_o, wr_en_o and dst_data_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue request, sampled while idle |
| offset_lo_i | input | 8 | Pattern bits 7:0 |
| offset_hi_i | input | 8 | Pattern bits 15:8 |
| exec_mask_i | input | 64 | Per-lane execution mask |
| src_data_i | input | 2048 | Source vector, lane L in bits 32L+31:32L |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle result pulse |
| wr_en_o | output | 64 | Per-lane write enable of the last result |
| dst_data_o | output | 2048 | Destination vector, lane L in bits 32L+31:32L |

## Verification
Every result is due on the 24th rising edge after the edge that accepted the start. The done pulse, the destination vector and the write-enable mask all change on that same edge. The driver records the cycle number of the accepting edge with each expected item it queues. The monitor samples on the falling edge after done_o rises, and it checks that exactly 24 cycles have passed, as well as the data and the enables. A done pulse with nothing queued counts as a failure, and so does an item left in the queue at the end. This catches both an early or late result and a start that was wrongly accepted while busy.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  parameter int unsigned LANES   = 64;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned LATENCY = 24;
  localparam int unsigned IDX_W  = $clog2(LANES);
  localparam int unsigned HALF_W = IDX_W - 1;
  localparam int unsigned PAT_W  = 16;
  localparam int unsigned CNT_W  = $clog2(LATENCY + 1);

  typedef enum logic {
    MODE_MASK = 1'b0,
    MODE_QUAD = 1'b1
  } swz_mode_e;

  typedef struct packed {
    swz_mode_e         mode;
    logic [HALF_W-1:0] xor_m;
    logic [HALF_W-1:0] or_m;
    logic [HALF_W-1:0] and_m;
  } pattern_t;
endpackage

// File: rtl/lsw_index.sv
module lsw_index
  import lsw_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic [PAT_W-1:0]         pattern_i,
  output logic [N_LANES*IDX_W-1:0] idx_o
);
  pattern_t pat;
  assign pat = pattern_t'(pattern_i);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam logic [IDX_W-1:0] LID = IDX_W'(g);
    logic [IDX_W-1:0]  quad_idx;
    logic [HALF_W-1:0] mask_lo;

    // quad: group base plus 2-bit selector for this slot
    assign quad_idx = {LID[IDX_W-1:2], pattern_i[2*(g%4) +: 2]};
    assign mask_lo  = ((LID[HALF_W-1:0] & pat.and_m) | pat.or_m) ^ pat.xor_m;

    assign idx_o[g*IDX_W +: IDX_W] = (pat.mode == MODE_QUAD) ? quad_idx
                                                             : {LID[IDX_W-1], mask_lo};
  end
endmodule

// File: rtl/lsw_xbar.sv
module lsw_xbar
  import lsw_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  parameter int unsigned DW      = DATA_W
) (
  input  logic [N_LANES*DW-1:0]    src_i,
  input  logic [N_LANES-1:0]       mask_i,
  input  logic [N_LANES*IDX_W-1:0] idx_i,
  output logic [N_LANES*DW-1:0]    data_o
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel = idx_i[g*IDX_W +: IDX_W];
    // inactive source lane reads as zero
    assign data_o[g*DW +: DW] = mask_i[sel] ? src_i[sel*DW +: DW] : '0;
  end
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
#(
  parameter int unsigned LAT = LATENCY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic fire_o,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign accept_o = start_i && !busy_q;
  assign fire_o   = busy_q && (cnt_q == CNT_LAST);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire_o;
      if (accept_o) begin
        cnt_q  <= CNT_LOAD;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_LAST;
        if (fire_o) busy_q <= 1'b0;
      end
    end
  end

  assert_accept_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (busy_q && cnt_q == CNT_LOAD));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !fire_o) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_LAST));
endmodule

// File: rtl/lane_swizzle_unit.sv
module lane_swizzle_unit
  import lsw_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [7:0]              offset_lo_i,
  input  logic [7:0]              offset_hi_i,
  input  logic [LANES-1:0]        exec_mask_i,
  input  logic [LANES*DATA_W-1:0] src_data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANES-1:0]        wr_en_o,
  output logic [LANES*DATA_W-1:0] dst_data_o
);
  logic [PAT_W-1:0]        pattern;
  logic [LANES*IDX_W-1:0]  idx;
  logic [LANES*DATA_W-1:0] swz_data;
  logic                    accept, fire;

  logic [LANES*DATA_W-1:0] stage_data_q, dst_q;
  logic [LANES-1:0]        stage_we_q, wr_en_q;

  assign pattern = {offset_hi_i, offset_lo_i};

  lsw_index #(.N_LANES(LANES)) u_index (
    .pattern_i (pattern),
    .idx_o     (idx)
  );

  lsw_xbar #(.N_LANES(LANES), .DW(DATA_W)) u_xbar (
    .src_i  (src_data_i),
    .mask_i (exec_mask_i),
    .idx_i  (idx),
    .data_o (swz_data)
  );

  lsw_ctrl #(.LAT(LATENCY)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .fire_o   (fire),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_data_q <= '0;
      stage_we_q   <= '0;
      wr_en_q      <= '0;
    end else begin
      if (accept) begin
        stage_data_q <= swz_data;
        stage_we_q   <= exec_mask_i;
      end
      if (fire) wr_en_q <= stage_we_q;
    end
  end

  // per-lane write: disabled lanes keep their old contents
  for (genvar g = 0; g < LANES; g++) begin : g_dst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      dst_q[g*DATA_W +: DATA_W] <= '0;
      else if (fire && stage_we_q[g])   dst_q[g*DATA_W +: DATA_W] <= stage_data_q[g*DATA_W +: DATA_W];
    end
  end

  assign dst_data_o = dst_q;
  assign wr_en_o    = wr_en_q;

  logic [LANES*DATA_W-1:0] keep_bits;
  for (genvar g = 0; g < LANES; g++) begin : g_keep
    assign keep_bits[g*DATA_W +: DATA_W] = {DATA_W{!wr_en_q[g]}};
  end

  assert_keep_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (((dst_q ^ $past(dst_q)) & keep_bits) == '0));
  assert_hold_between_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(dst_q) && $stable(wr_en_q)));
  assert_empty_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wr_en_q == '0) |-> (dst_q == $past(dst_q)));
  assert_stage_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(stage_we_q) && $stable(stage_data_q)));
endmodule

// File: tb/lane_swizzle_unit_tb_top.sv
`timescale 1ns/1ps
module lane_swizzle_unit_tb_top;
  localparam int NL = 64;
  localparam int DW = 32;
  localparam int LAT = 24;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [7:0]     offset_lo_i = '0, offset_hi_i = '0;
  logic [NL-1:0]  exec_mask_i = '0;
  logic [NL*DW-1:0] src_data_i = '0;
  logic           busy_o, done_o;
  logic [NL-1:0]  wr_en_o;
  logic [NL*DW-1:0] dst_data_o;

  lane_swizzle_unit dut_i (
    .clk_i, .rst_ni, .start_i, .offset_lo_i, .offset_hi_i, .exec_mask_i,
    .src_data_i, .busy_o, .done_o, .wr_en_o, .dst_data_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  logic [NL*DW-1:0] q_dst[$];
  logic [NL-1:0]    q_we[$];
  int               q_cyc[$];
  string            q_tag[$];
  logic [DW-1:0]    model_dst[NL];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic int src_index(input logic [15:0] pat, input int l);
    int a, o, x, i;
    if (pat[15]) return (l & ~3) + ((pat >> (2 * (l % 4))) & 3);
    a = pat[4:0]; o = pat[9:5]; x = pat[14:10];
    i = (((l % 32) & a) | o) ^ x;
    return (l >= 32) ? i + 32 : i;
  endfunction

  // driver: computes expectation, queues it, issues the op
  task automatic issue(input logic [7:0] lo, input logic [7:0] hi,
                       input logic [NL-1:0] mask, input logic [31:0] seed,
                       input string tag);
    logic [DW-1:0]    src[NL];
    logic [NL*DW-1:0] flat, exp;
    logic [15:0]      pat;
    pat = {hi, lo};
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    for (int l = 0; l < NL; l++) begin
      src[l] = seed ^ (32'h0101_0101 * l) ^ {8'(l), 24'h0};
      if (src[l] == '0) src[l] = 32'hDEAD_0000 | l;
      flat[l*DW +: DW] = src[l];
    end
    for (int l = 0; l < NL; l++) begin
      int s;
      if (mask[l]) begin
        s = src_index(pat, l);
        model_dst[l] = mask[s] ? src[s] : '0;
      end
      exp[l*DW +: DW] = model_dst[l];
    end
    offset_lo_i = lo; offset_hi_i = hi; exec_mask_i = mask; src_data_i = flat;
    start_i = 1'b1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    q_dst.push_back(exp); q_we.push_back(mask); q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk_i);
    check(busy_o === 1'b1, "R9", "busy after accept", 64'(busy_o), 64'd1);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o === 1'b1) begin
      if (q_tag.size() == 0) begin
        check(1'b0, "R9", "done with nothing outstanding", 64'd1, 64'd0);
      end else begin
        logic [NL*DW-1:0] ed;
        logic [NL-1:0] ew;
        int ec, bad;
        string t;
        ed = q_dst.pop_front(); ew = q_we.pop_front(); ec = q_cyc.pop_front(); t = q_tag.pop_front();
        check(cyc - ec == LAT, "R8", {t, " latency"}, 64'(cyc - ec), 64'(LAT));
        check(wr_en_o === ew, t, "wr_en", wr_en_o, ew);
        bad = -1;
        for (int l = 0; l < NL; l++)
          if (bad < 0 && dst_data_o[l*DW +: DW] !== ed[l*DW +: DW]) bad = l;
        check(bad < 0, t, "dst lane data",
              (bad < 0) ? 64'd0 : {32'(bad), dst_data_o[((bad < 0) ? 0 : bad)*DW +: DW]},
              (bad < 0) ? 64'd0 : {32'(bad), ed[((bad < 0) ? 0 : bad)*DW +: DW]});
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    report();
  end

  initial begin
    for (int l = 0; l < NL; l++) model_dst[l] = '0;
    repeat (3) @(negedge clk_i);
    check(busy_o === 1'b0 && done_o === 1'b0, "R10", "busy/done in reset",
          {busy_o, done_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(wr_en_o === '0, "R10", "wr_en after reset", wr_en_o, 64'd0);
    check(dst_data_o === '0, "R10", "dst after reset", dst_data_o[63:0], 64'd0);

    // quad reverse, all lanes active
    issue(8'h1B, 8'h80, {NL{1'b1}}, 32'h1234_5678, "R2");
    // quad with junk in bits 14:8 and sparse mask
    issue(8'h1B, 8'hFF, 64'hF0F0_5A5A_0FF0_A5C3, 32'h0BAD_F00D, "R3");
    // mask mode neighbour swap: and=1F or=0 xor=01
    issue(8'h1F, 8'h04, {NL{1'b1}}, 32'hCAFE_0001, "R4");
    // mask mode broadcast lane 7: and=0 or=7 xor=0
    issue(8'hE0, 8'h00, {NL{1'b1}}, 32'h5555_AAAA, "R4");
    // mask mode mixed fields, sparse mask (inactive sources, kept lanes)
    issue(8'hA3, 8'h4D, 64'h8421_F00F_1248_0FF1, 32'h7777_1111, "R6");
    issue(8'h1F, 8'h00, 64'h5555_5555_AAAA_AAAA, 32'h3C3C_C3C3, "R5");
    // empty mask
    issue(8'h1B, 8'h80, '0, 32'h9999_9999, "R7");
    // quad broadcast slot 2, pattern bits from both offsets (R1)
    issue(8'hAA, 8'hC3, {NL{1'b1}}, 32'h0F0F_0F0F, "R1");

    // start while busy is ignored
    issue(8'hE4, 8'h80, 64'hFFFF_0000_FFFF_0000, 32'h2468_ACE0, "R9");
    for (int k = 0; k < 5; k++) begin
      offset_lo_i = 8'h00; offset_hi_i = 8'h00; exec_mask_i = {NL{1'b1}};
      src_data_i = {NL{32'hFFFF_FFFF}};
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      @(negedge clk_i);
    end
    while (busy_o) @(negedge clk_i);
    repeat (LAT + 8) @(negedge clk_i);
    check(q_tag.size() == 0, "R9", "outstanding items at end", 64'(q_tag.size()), 64'd0);
    report();
  end
endmodule